// File: doc/BRIEF.md
# Edge-Selected Capture Unit

This block records the moment an external event happens. It has four channels. Each channel watches one asynchronous input pin. When the configured edge appears on that pin, the channel copies the running 32-bit timer count into its own capture register. The count is generated elsewhere and fed in as an input. Each channel is configured on its own:
- it can respond to rising edges, to falling edges, or to either;
- it can also raise a pending-interrupt flag each time it loads.

The flags live in an 8-bit pending vector that is shared with other timer sources. The capture flags occupy bits 4 to 7 of that vector, and this unit holds bits 0 to 3 at zero. Software clears a flag by writing a one to its bit. If a capture lands in the same cycle as the clear, the flag stays set, so that event is not lost.

The block has no streamed data, so every pin is plain control or status. Capture values and flags are continuously visible for readback. Configuration is written as one word, and a single-cycle write strobe applies it.

Top module: `cap_unit`

## Requirements
- R1: After reset, all capture registers read 0, the flag vector reads 0, the configuration reads 0 and `irq_o` is low.
- R2: When a channel's rise enable (bit 0 of its 3-bit field) is set, a 0-to-1 change on its input loads that channel's capture register. The value loaded is the `count_i` sampled on the third rising clock edge after the input change: two synchroniser flops, then one edge-detect stage.
- R3: When a channel's fall enable (bit 1 of its field) is set, a 1-to-0 change on its input loads the capture register with the same latency as R2.
- R4: With both edge enables set, a channel captures on every change of its input.
- R5: An input edge that its channel has not enabled causes no load; the capture register keeps its last value until a qualifying edge arrives.
- R6: When a channel's interrupt enable (bit 2 of its field) is set, each load sets flag bit 4+n for channel n, in the same clock edge as the load. Bits 0 to 3 of `flags_o` always read 0.
- R7: With interrupt enable clear, the capture register still loads but the channel's flag is not set.
- R8: Writing the clear strobe with a 1 in a flag bit clears that flag. A 0 leaves the flag unchanged.
- R9: If a flag-setting capture and a clear of the same flag occur in the same cycle, the flag stays set.
- R10: An event on one channel leaves the capture register and flag of every other channel unchanged.
- R11: `irq_o` is high exactly when any flag bit is set.
- R12: A configuration write takes effect on the next clock edge and reads back unchanged on `ctl_o`. Channel n uses bits [3n+2:3n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 32 | Running timer count to be captured |
| cap_in_i | input | 4 | Asynchronous capture pins, one per channel |
| ctl_we_i | input | 1 | Configuration write strobe |
| ctl_wdata_i | input | 12 | Configuration word, 3 bits per channel (irq, fall, rise) |
| ctl_o | output | 12 | Current configuration |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_wdata_i | input | 8 | Write-1-to-clear mask over the pending vector |
| cap_o | output | 128 | Capture registers, channel n at bits [32n+31:32n] |
| flags_o | output | 8 | Pending vector, capture flags in bits 4 to 7 |
| irq_o | output | 1 | OR of all capture flags |

## Verification
The capture path is driven with single-pin transitions against a count that changes every cycle, so a load that is one cycle early or late shows up as a wrong value.

The four channels carry different modes:
- rise only;
- fall only;
- both edges;
- none.

The same pair of transitions on each channel therefore separates edge polarity from edge qualification. Unselected edges and cross-channel traffic are checked as the absence of any change on the other capture registers. Flag handling is exercised three ways:
- a plain one-bit clear;
- a write of zeros;
- a clear timed into the exact cycle of a new capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= async_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

  // An edge is reported for one cycle only
  assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  assert_fall_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  chan_cfg_t     cfg_i,
  input  logic          clr_i,
  output logic [CW-1:0] cap_o,
  output logic          flag_o
);
  logic          evt;
  logic [CW-1:0] cap_q;
  logic          flag_q;

  assign evt = (rise_i & cfg_i.rise_en) | (fall_i & cfg_i.fall_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (evt) cap_q <= count_i;
      // a new event wins over a clear in the same cycle
      if (evt && cfg_i.irq_en) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  assert_rise_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && cfg_i.rise_en) |=> cap_q == $past(count_i));
  assert_fall_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && cfg_i.fall_en) |=> cap_q == $past(count_i));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_i || fall_i) |=> $stable(cap_q));
  assert_flag_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cfg_i.irq_en));
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_i && !fall_i) |=> !flag_q);
  assert_keep_on_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && rise_i && cfg_i.rise_en && cfg_i.irq_en) |=> flag_q);
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CW       = 32,
  parameter int SYNC     = 2,
  parameter int IRQW     = 8,
  parameter int FLAG_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        count_i,
  input  logic [NCH-1:0]       cap_in_i,
  input  logic                 ctl_we_i,
  input  logic [NCH*CFG_W-1:0] ctl_wdata_i,
  output logic [NCH*CFG_W-1:0] ctl_o,
  input  logic                 clr_we_i,
  input  logic [IRQW-1:0]      clr_wdata_i,
  output logic [NCH*CW-1:0]    cap_o,
  output logic [IRQW-1:0]      flags_o,
  output logic                 irq_o
);
  localparam int CTLW = NCH * CFG_W;

  logic [CTLW-1:0] ctl_q;
  logic [NCH-1:0]  rise, fall, flag_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end
  assign ctl_o = ctl_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg = chan_cfg_t'(ctl_q[c*CFG_W +: CFG_W]);

    cap_edge_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(cap_in_i[c]),
      .rise_o(rise[c]), .fall_o(fall[c])
    );

    cap_channel #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .count_i(count_i),
      .rise_i(rise[c]), .fall_i(fall[c]), .cfg_i(cfg),
      .clr_i(clr_we_i & clr_wdata_i[FLAG_LSB+c]),
      .cap_o(cap_o[c*CW +: CW]), .flag_o(flag_vec[c])
    );
  end

  always_comb begin
    flags_o = '0;
    flags_o[FLAG_LSB +: NCH] = flag_vec;
  end
  assign irq_o = |flag_vec;

  assert_cfg_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> ctl_o == $past(ctl_wdata_i));
  assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ($countones(flags_o) != 0));
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_o) == $countones(flag_vec));
endmodule

// File: tb/cap_unit_test.sv
module cap_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  count_i = '0;
  logic [3:0]   cap_in_i = '0;
  logic         ctl_we_i = 1'b0;
  logic [11:0]  ctl_wdata_i = '0;
  logic [11:0]  ctl_o;
  logic         clr_we_i = 1'b0;
  logic [7:0]   clr_wdata_i = '0;
  logic [127:0] cap_o;
  logic [7:0]   flags_o;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  bit running = 0;
  bit done = 0;

  typedef struct {
    int          ch;
    logic [31:0] val;
  } exp_t;
  exp_t q[$];
  logic [31:0] last_seen [4];

  always #5 clk = ~clk;
  always @(posedge clk) count_i <= count_i + 32'd1;

  cap_unit uut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .cap_in_i(cap_in_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .ctl_o(ctl_o),
    .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i), .cap_o(cap_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] capv(int ch);
    return cap_o[ch*32 +: 32];
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every change of a capture register must match the queue head
  always @(negedge clk) begin
    if (running) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (capv(ch) !== last_seen[ch]) begin
          if (q.size() == 0) begin
            check(0, "R5/R10 unexpected load", capv(ch), last_seen[ch]);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.ch == ch && e.val == capv(ch), "R2/R3/R4 captured value",
                  {ch[31:0], capv(ch)}, {e.ch[31:0], e.val});
          end
          last_seen[ch] = capv(ch);
        end
      end
    end
  end

  // driver: change one pin, predict the load, wait past the latency
  task automatic drive(int ch, logic lvl, bit expect_load);
    @(negedge clk);
    cap_in_i[ch] = lvl;
    if (expect_load) q.push_back('{ch, count_i + 32'd2});
    repeat (6) @(negedge clk);
  endtask

  task automatic write_cfg(logic [11:0] v);
    @(negedge clk);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk);
    ctl_we_i = 1'b0;
  endtask

  task automatic clear(logic [7:0] m);
    @(negedge clk);
    clr_we_i = 1'b1; clr_wdata_i = m;
    @(negedge clk);
    clr_we_i = 1'b0; clr_wdata_i = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(0, "watchdog", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(cap_o == '0, "R1 capture regs", cap_o, 0);
    check(flags_o == 8'h00 && !irq_o, "R1 flags", flags_o, 0);
    check(ctl_o == '0, "R1 config", ctl_o, 0);
    for (int i = 0; i < 4; i++) last_seen[i] = '0;
    running = 1;

    // ch0 rise+irq, ch1 fall, ch2 both+irq, ch3 none
    write_cfg({3'b000, 3'b111, 3'b010, 3'b101});
    check(ctl_o == 12'h1D5, "R12 config readback", ctl_o, 12'h1D5);

    drive(0, 1'b1, 1);
    check(flags_o == 8'h10, "R6 flag bit 4", flags_o, 8'h10);
    check(irq_o == 1'b1, "R11 irq high", irq_o, 1);
    keep0 = capv(0);
    drive(0, 1'b0, 0);
    check(capv(0) == keep0, "R5 fall ignored on rise channel", capv(0), keep0);

    drive(1, 1'b1, 0);
    check(capv(1) == 32'd0, "R5 rise ignored on fall channel", capv(1), 0);
    drive(1, 1'b0, 1);
    check(flags_o == 8'h10, "R7 no flag without irq enable", flags_o, 8'h10);
    check(capv(1) != 32'd0, "R3 fall channel loaded", capv(1), 1);

    drive(2, 1'b1, 1);
    drive(2, 1'b0, 1);
    check(flags_o == 8'h50, "R4 both-edge flag", flags_o, 8'h50);
    check(capv(0) == keep0, "R10 ch0 untouched by ch2", capv(0), keep0);

    drive(3, 1'b1, 0);
    drive(3, 1'b0, 0);
    check(capv(3) == 32'd0, "R5 disabled channel", capv(3), 0);

    clear(8'h10);
    check(flags_o == 8'h40, "R8 clear bit 4", flags_o, 8'h40);
    clear(8'h00);
    check(flags_o == 8'h40, "R8 zero write keeps flags", flags_o, 8'h40);
    clear(8'h4F);
    check(flags_o == 8'h00 && !irq_o, "R8/R11 all clear", {irq_o, flags_o}, 0);

    // R9: clear lands in the same cycle as a new capture of ch0
    @(negedge clk);
    cap_in_i[0] = 1'b1;
    q.push_back('{0, count_i + 32'd2});
    @(negedge clk);
    @(negedge clk);
    clr_we_i = 1'b1; clr_wdata_i = 8'h10;
    @(negedge clk);
    clr_we_i = 1'b0; clr_wdata_i = '0;
    check(flags_o[4] == 1'b1, "R9 capture beats clear", flags_o, 8'h10);
    repeat (3) @(negedge clk);
    clear(8'h10);
    check(flags_o == 8'h00, "R8 clear after clash", flags_o, 0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all predicted loads seen", q.size(), 0);
    running = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule